// File: doc/BRIEF.md
# Shift-Register Pulse Divider

This block divides a stream of enabled clock cycles by a fixed integer. Rather than incrementing a binary counter, it steps a maximal-length shift register whose feedback bit is the XNOR of a few tap positions. While it runs, it compares the register contents against one precomputed pattern. When the register matches that pattern, the single output goes high. On the next enabled edge the register reloads all zeros, so the sequence starts over on its own.

The divisor is fixed when the block is built. Elaboration works out three things from it: the register width, the tap set for that width and the matching pattern. A per-width tap table covers register widths 3 to 31. A divisor below 4 or above 2^30 stops elaboration with an error.

The block has no data stream, so it has no valid/ready handshake. Its three inputs and one output are plain level signals. The clock enable qualifies every flop, including the clear path. When the enable is low, nothing changes.

Top module: `lfsr_pulse_divider`

## Requirements
- R1: After an enabled clear, `pulse` stays low through the next DIVISOR-2 enabled edges. It rises only once DIVISOR-1 enabled edges have passed since the clearing edge.
- R2: Without a clear, `pulse` is high on exactly one enabled cycle out of every DIVISOR enabled cycles. This holds for divisors on either side of a power of two, for example 7, 8, 9, 15, 16, 17 and 33.
- R3: `pulse` stays high for exactly one enabled cycle. The enabled edge that ends that cycle drops it, and it stays low on the cycle that follows. While `step_en` is low, `pulse` holds its current level.
- R4: While `step_en` is low, the count and `pulse` do not change, and `sync_clr` has no effect. After such a stretch, the next pulse lands exactly where it would have landed if those cycles had been removed.
- R5: With `step_en` high, `sync_clr` restarts the period from the start state at any point in the count, including the cycle in which `pulse` is high. The next pulse then follows the timing given in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| step_en | input | 1 | Clock enable; only edges with this high advance or clear the register |
| sync_clr | input | 1 | Synchronous restart, acting only on enabled edges |
| pulse | output | 1 | High during the enabled cycle that ends each period |

## Verification
A single wrong bit in the shift register moves the register off its sequence. This shows up at the port as a pulse that comes at the wrong spacing or never comes at all. It becomes visible no later than the end of the current period, which is at most DIVISOR enabled cycles away. A wrong tap set or a wrong matching pattern changes the spacing between pulses, and a wrong restart path breaks the single-cycle width. Both show up on the first pulse after a clear. Running divisors just below and just above each power of two exercises the width choice and the top tap in every register size used.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  // Smallest register width b with n < 2**b.
  function automatic int unsigned reg_width(input longint unsigned n);
    int unsigned b;
    b = 1;
    while (n >= (64'd1 << b)) b++;
    return b;
  endfunction

  // One-hot bit for tap position t (positions start at 1; 0 means unused).
  function automatic logic [31:0] tap_bit(input int unsigned t);
    return (t == 0) ? 32'd0 : (32'd1 << (t - 1));
  endfunction

  function automatic logic [31:0] tap_set(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    return tap_bit(a) | tap_bit(b) | tap_bit(c) | tap_bit(d);
  endfunction

  // Maximal-length XNOR tap set for each supported width.
  function automatic logic [31:0] tap_mask(input int unsigned w);
    case (w)
      3:  return tap_set(3, 2, 0, 0);
      4:  return tap_set(4, 3, 0, 0);
      5:  return tap_set(5, 3, 0, 0);
      6:  return tap_set(6, 5, 0, 0);
      7:  return tap_set(7, 6, 0, 0);
      8:  return tap_set(8, 6, 5, 4);
      9:  return tap_set(9, 5, 0, 0);
      10: return tap_set(10, 7, 0, 0);
      11: return tap_set(11, 9, 0, 0);
      12: return tap_set(12, 6, 4, 1);
      13: return tap_set(13, 4, 3, 1);
      14: return tap_set(14, 5, 3, 1);
      15: return tap_set(15, 14, 0, 0);
      16: return tap_set(16, 15, 13, 4);
      17: return tap_set(17, 14, 0, 0);
      18: return tap_set(18, 11, 0, 0);
      19: return tap_set(19, 6, 2, 1);
      20: return tap_set(20, 17, 0, 0);
      21: return tap_set(21, 19, 0, 0);
      22: return tap_set(22, 21, 0, 0);
      23: return tap_set(23, 18, 0, 0);
      24: return tap_set(24, 23, 22, 17);
      25: return tap_set(25, 22, 0, 0);
      26: return tap_set(26, 6, 2, 1);
      27: return tap_set(27, 5, 2, 1);
      28: return tap_set(28, 25, 0, 0);
      29: return tap_set(29, 27, 0, 0);
      30: return tap_set(30, 6, 4, 1);
      31: return tap_set(31, 28, 0, 0);
      default: return 32'd0;
    endcase
  endfunction

  // Register contents after n-1 enabled steps from all zeros.
  function automatic logic [31:0] match_pattern(input longint unsigned n);
    int unsigned w;
    logic [31:0] lim;
    logic [31:0] msk;
    logic [31:0] s;
    w   = reg_width(n);
    lim = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    msk = tap_mask(w);
    s   = 32'd0;
    for (longint unsigned i = 1; i < n; i++) begin
      s = ((s << 1) & lim) | {31'd0, ~^(s & msk)};
    end
    return s;
  endfunction

endpackage

// File: rtl/lfsr_div_shift.sv
module lfsr_div_shift #(
  parameter int unsigned     WIDTH = 7,
  parameter logic [WIDTH-1:0] TAPS = '0
) (
  input  logic             clk,
  input  logic             step_en,
  input  logic             restart,
  output logic [WIDTH-1:0] state_q
);

  logic feed_bit;

  // XNOR feedback: the all-ones state is the lock-up state, so all zeros is a legal start.
  assign feed_bit = ~^(state_q & TAPS);

  // Bit 0 takes the feedback; every other bit takes its lower neighbour.
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (step_en) state_q[0] <= restart ? 1'b0 : feed_bit;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (step_en) state_q[i] <= restart ? 1'b0 : state_q[i-1];
      end
    end
  end

endmodule

// File: rtl/lfsr_div_match.sv
module lfsr_div_match #(
  parameter int unsigned      WIDTH   = 7,
  parameter logic [WIDTH-1:0] PATTERN = '0
) (
  input  logic [WIDTH-1:0] state_q,
  output logic             hit
);

  assign hit = (state_q == PATTERN);

endmodule

// File: rtl/lfsr_pulse_divider.sv
module lfsr_pulse_divider
  import lfsr_div_pkg::*;
#(
  parameter int unsigned DIVISOR = 100
) (
  input  logic clk,
  input  logic step_en,
  input  logic sync_clr,
  output logic pulse
);

  localparam int unsigned     W     = reg_width(longint'(DIVISOR));
  localparam logic [31:0]     MASK  = tap_mask(W);
  localparam logic [31:0]     TERMW = match_pattern(longint'(DIVISOR));
  localparam logic [W-1:0]    TAPS  = MASK[W-1:0];
  localparam logic [W-1:0]    TERM  = TERMW[W-1:0];

  if (DIVISOR < 4 || DIVISOR > (32'd1 << 30)) begin : g_bad_divisor
    $error("lfsr_pulse_divider: DIVISOR %0d outside 4..2^30", DIVISOR);
  end
  if (TERM == '0) begin : g_bad_pattern
    $error("lfsr_pulse_divider: matching pattern is all zeros");
  end

  logic [W-1:0] lfsr_q;
  logic         hit;
  logic         restart;

  assign restart = hit | sync_clr;
  assign pulse   = hit;

  lfsr_div_shift #(.WIDTH(W), .TAPS(TAPS)) u_shift (
    .clk     (clk),
    .step_en (step_en),
    .restart (restart),
    .state_q (lfsr_q)
  );

  lfsr_div_match #(.WIDTH(W), .PATTERN(TERM)) u_match (
    .state_q (lfsr_q),
    .hit     (hit)
  );

  // Assertion support: a plain binary count of enabled cycles, started by the first clear.
  logic         chk_live = 1'b0;
  logic [W-1:0] chk_cnt;

  always_ff @(posedge clk) begin
    if (step_en) begin
      if (sync_clr) chk_live <= 1'b1;
      chk_cnt <= (sync_clr || pulse) ? '0 : chk_cnt + 1'b1;
    end
  end

  a_r1_zero_after_clear: assert property (@(posedge clk) disable iff (!chk_live)
    step_en && sync_clr |=> lfsr_q == '0);
  a_r5_restart_on_pulse: assert property (@(posedge clk) disable iff (!chk_live || sync_clr)
    step_en && pulse |=> lfsr_q == '0);
  a_r2_pulse_at_period: assert property (@(posedge clk) disable iff (!chk_live)
    pulse |-> chk_cnt == W'(DIVISOR - 1));
  a_r2_period_gives_pulse: assert property (@(posedge clk) disable iff (!chk_live)
    chk_cnt == W'(DIVISOR - 1) |-> pulse);
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!chk_live || sync_clr)
    step_en && pulse |=> !pulse);
  a_r4_frozen: assert property (@(posedge clk) disable iff (!chk_live)
    !step_en |=> $stable(lfsr_q) && $stable(pulse));

endmodule

// File: tb/lfsr_pulse_divider_tb_top.sv
`timescale 1ns/1ps
module lfsr_pulse_divider_tb_top;

  localparam int NK = 9;

  function automatic int div_of(input int k);
    case (k)
      0: return 4;
      1: return 5;
      2: return 7;
      3: return 8;
      4: return 9;
      5: return 15;
      6: return 16;
      7: return 17;
      default: return 33;
    endcase
  endfunction

  logic          clk = 1'b0;
  logic          ce  = 1'b0;
  logic          clr = 1'b0;
  logic [NK-1:0] tick;
  int            exp_cnt [NK];
  int            vectors = 0;
  int            fails   = 0;
  bit            finished = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar k = 0; k < NK; k++) begin : g_dut
    lfsr_pulse_divider #(.DIVISOR(div_of(k))) dut_i (
      .clk      (clk),
      .step_en  (ce),
      .sync_clr (clr),
      .pulse    (tick[k])
    );
  end

  // Reference: binary count of enabled cycles since the last restart.
  always @(posedge clk) begin
    for (int k = 0; k < NK; k++) begin
      if (ce) exp_cnt[k] <= (clr || exp_cnt[k] == div_of(k) - 1) ? 0 : exp_cnt[k] + 1;
    end
  end

  // Sampled at the falling edge; ce/clr still show what the last rising edge saw.
  task automatic check_all(input string force_tag);
    for (int k = 0; k < NK; k++) begin
      logic  expv;
      string tag;
      expv = (exp_cnt[k] == div_of(k) - 1);
      if (force_tag != "")   tag = force_tag;
      else if (expv)         tag = "R3";
      else if (ce && clr)    tag = "R5";
      else if (!ce)          tag = "R4";
      else                   tag = "R2";
      vectors++;
      if (tick[k] !== expv) begin
        fails++;
        $display("FAIL %s N=%0d pulse=%0b expected=%0b at %0t", tag, div_of(k), tick[k], expv, $time);
      end
    end
  endtask

  task automatic run(input int cycles, input int ce_pct, input int clr_per, input string force_tag);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check_all(force_tag);
      ce  = ($urandom_range(99) < ce_pct);
      clr = (clr_per > 0) ? ($urandom_range(clr_per - 1) == 0) : 1'b0;
    end
  endtask

  initial begin
    for (int k = 0; k < NK; k++) exp_cnt[k] = 0;
    ce  = 1'b1;
    clr = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all("R1");          // reset state: every pulse low just after the clear
    clr = 1'b0;
    run(40, 100, 0, "R1");    // first periods after the clear, enable held high
    run(80, 100, 0, "");      // free running, R2/R3
    run(1500, 70, 0, "");     // random enable gaps, R2/R3/R4
    run(1500, 60, 40, "");    // random mid-count restarts, R5
    run(300, 10, 3, "");      // mostly idle with frequent clears while disabled, R4
    run(200, 100, 0, "");     // settle back into plain counting
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule